// File: doc/BRIEF.md
# DRAM Periodic Maintenance Scheduler

This block tells a DRAM command sequencer when to run two kinds of background upkeep: reading the device's temperature status register (mode register 4) and issuing short ZQ impedance calibration (ZQCS). Neither schedule counts clock cycles. Both count strobes from the refresh timer, so each period is an integer number of average refresh intervals. For example, a 0.4 s calibration period with a 7.8 µs refresh interval needs a count of 0xC852.

Both periods are held in one 32-bit configuration register that software writes through a simple port. A write-protect input blocks all writes. Temperature reads run only while the refresh-rate-adjust enable is high. Each schedule raises its own request line, and that line stays high until the sequencer acknowledges it. When both requests are pending, calibration is offered first.

Top module: `dram_maint_sched`

## Requirements
- R1: After reset the configuration reads as 0, and both `temp_req` and `zq_req` are low.
- R2: A write with `wp_en` low loads `cfg_wdata` into the register, and it shows on `cfg_rdata` one cycle later. Bits 31:16 hold the temperature interval T and bits 15:0 hold the calibration count C.
- R3: A write while `wp_en` is high leaves the register unchanged.
- R4: While `rate_adj_en` is high, a temperature request becomes pending on every (T+1)-th `ref_tick`. It is visible the cycle after that tick.
- R5: While `rate_adj_en` is low, no temperature request is raised and the temperature count is held at its start. After enabling, the first request comes on the (T+1)-th tick.
- R6: With C nonzero, a calibration request becomes pending on every C-th `ref_tick`, and the counter restarts at each expiry.
- R7: With C equal to 0, no calibration request is raised.
- R8: A pending request stays high until its acknowledge is sampled, and it is low the next cycle. An expiry during a pending request merges into it. An expiry in the same cycle as the acknowledge keeps the request high.
- R9: A write that changes a field restarts that field's count, and a tick in the same cycle is not counted. A write that leaves a field's value unchanged does not disturb its count.
- R10: While a calibration request is pending, `temp_req` is held low and the temperature request stays pending. It appears once the calibration request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per average refresh interval |
| rate_adj_en | input | 1 | Enables the temperature-read schedule |
| wp_en | input | 1 | Write protect for the configuration register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration value |
| temp_req | output | 1 | Temperature-status read request |
| temp_ack | input | 1 | Acknowledge for the temperature request |
| zq_req | output | 1 | ZQCS calibration request |
| zq_ack | input | 1 | Acknowledge for the calibration request |

## Verification
A request becomes visible one cycle after the rising edge that samples its expiring `ref_tick`. It falls one cycle after the edge that samples its acknowledge. A written value shows on `cfg_rdata` one cycle after the write. The bench drives inputs and samples outputs on falling edges, so every output it reads has settled from the rising edge before. A behavioural model, based only on tick counts, advances on each rising edge and is compared with all three outputs on every falling edge. Directed phases count requests over fixed tick windows to cover each requirement.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int unsigned DMS_FIELD_W = 16;

  typedef struct packed {
    logic en;      // schedule may run
    logic reload;  // restart count from load value
    logic tick;    // one refresh interval elapsed
  } tmr_ctl_t;
endpackage

// File: rtl/maint_timer.sv
module maint_timer
  import dms_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_ctl_t     ctl,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (ctl.reload || !ctl.en) begin
      cnt_d = load_val;
    end else if (ctl.tick) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = load_val;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (ctl.tick && ctl.en && !ctl.reload));
endmodule

// File: rtl/req_hold.sv
module req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q && !ack) || set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !pend_q);
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !set) |=> !pend_q);
endmodule

// File: rtl/dram_maint_sched.sv
module dram_maint_sched
  import dms_pkg::*;
#(
  parameter int unsigned FIELD_W = DMS_FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_tick,
  input  logic                 rate_adj_en,
  input  logic                 wp_en,
  input  logic                 cfg_we,
  input  logic [2*FIELD_W-1:0] cfg_wdata,
  output logic [2*FIELD_W-1:0] cfg_rdata,
  output logic                 temp_req,
  input  logic                 temp_ack,
  output logic                 zq_req,
  input  logic                 zq_ack
);
  localparam int unsigned REG_W = 2 * FIELD_W;

  logic [REG_W-1:0]   cfg_q, cfg_d;
  logic               wr_ok, cfg_en;
  logic [FIELD_W-1:0] temp_ivl_d, cal_cnt_d, cal_cnt_q;
  tmr_ctl_t           temp_ctl, cal_ctl;
  logic               temp_set, zq_set;
  logic               temp_pend, zq_pend;

  // register write path
  always_comb begin
    wr_ok  = cfg_we && !wp_en;
    cfg_en = wr_ok;
    cfg_d  = wr_ok ? cfg_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_rdata  = cfg_q;
  assign temp_ivl_d = cfg_d[REG_W-1:FIELD_W];
  assign cal_cnt_d  = cfg_d[FIELD_W-1:0];
  assign cal_cnt_q  = cfg_q[FIELD_W-1:0];

  // timer controls: reload when a write changes the field
  always_comb begin
    temp_ctl.en     = rate_adj_en;
    temp_ctl.reload = wr_ok && (temp_ivl_d != cfg_q[REG_W-1:FIELD_W]);
    temp_ctl.tick   = ref_tick;
    cal_ctl.en      = (cal_cnt_d != '0);
    cal_ctl.reload  = wr_ok && (cal_cnt_d != cal_cnt_q);
    cal_ctl.tick    = ref_tick;
  end

  maint_timer #(.W(FIELD_W)) u_temp_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (temp_ctl),
    .load_val (temp_ivl_d),
    .expire   (temp_set)
  );

  maint_timer #(.W(FIELD_W)) u_cal_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (cal_ctl),
    .load_val (cal_cnt_d - 1'b1),
    .expire   (zq_set)
  );

  req_hold u_temp_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (temp_set),
    .ack   (temp_ack),
    .pend  (temp_pend)
  );

  req_hold u_zq_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (zq_set),
    .ack   (zq_ack),
    .pend  (zq_pend)
  );

  // calibration is offered ahead of the temperature read
  assign zq_req   = zq_pend;
  assign temp_req = temp_pend && !zq_pend;

  // R3
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wp_en) |=> $stable(cfg_rdata));
  // R10
  zq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(temp_req && zq_req));
  // R5
  temp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_adj_en |=> !$rose(temp_pend));
  // R7
  cal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cal_cnt_q == '0) && !cfg_we) |-> !zq_set);
endmodule

// File: tb/test_dram_maint_sched.sv
module test_dram_maint_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, rate_adj_en = 1'b0, wp_en = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        temp_req, temp_ack = 1'b0, zq_req, zq_ack = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0, auto_ack = 1'b0, run_cmp = 1'b0;

  // reference model state
  logic [31:0] m_cfg;
  int m_tn, m_zn;
  bit m_tp, m_zp;

  always #4 clk = ~clk;

  dram_maint_sched i_dram_maint_sched (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_adj_en(rate_adj_en),
    .wp_en(wp_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .temp_req(temp_req), .temp_ack(temp_ack), .zq_req(zq_req), .zq_ack(zq_ack)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model: counts ticks since the last (re)start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_tn = 0; m_zn = 0; m_tp = 0; m_zp = 0;
    end else begin
      int t_ivl, c_cnt;
      bit wr, t_exp, z_exp;
      logic [31:0] nc;
      t_ivl = m_cfg[31:16];
      c_cnt = m_cfg[15:0];
      wr = cfg_we && !wp_en;
      nc = wr ? cfg_wdata : m_cfg;
      t_exp = 0; z_exp = 0;
      if ((wr && nc[31:16] != m_cfg[31:16]) || !rate_adj_en) m_tn = 0;
      else if (ref_tick) begin
        m_tn++;
        if (m_tn == t_ivl + 1) begin t_exp = 1; m_tn = 0; end
      end
      if ((wr && nc[15:0] != m_cfg[15:0]) || nc[15:0] == 0) m_zn = 0;
      else if (ref_tick) begin
        m_zn++;
        if (m_zn == c_cnt) begin z_exp = 1; m_zn = 0; end
      end
      m_tp = (m_tp && !temp_ack) || t_exp;
      m_zp = (m_zp && !zq_ack) || z_exp;
      m_cfg = nc;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(cfg_rdata == m_cfg, "R2/R3/R9 model cfg_rdata", cfg_rdata, m_cfg);
      chk(zq_req == m_zp, "R6/R7/R8/R9 model zq_req", zq_req, m_zp);
      chk(temp_req == (m_tp && !m_zp), "R4/R5/R8/R10 model temp_req", temp_req, m_tp && !m_zp);
    end
  end

  // one cycle: drive at falling edge, return at next falling edge
  task automatic step(input bit tk, input bit ta, input bit za);
    ref_tick = tk;
    temp_ack = ta | (auto_ack & temp_req);
    zq_ack   = za | (auto_ack & zq_req);
    @(negedge clk);
    ref_tick = 0; temp_ack = 0; zq_ack = 0;
  endtask

  task automatic wr(input logic [31:0] d, input bit wp);
    cfg_we = 1; cfg_wdata = d; wp_en = wp;
    step(0, 0, 0);
    cfg_we = 0; wp_en = 0;
  endtask

  task automatic ticks(input int n, output int tr, output int zr);
    tr = 0; zr = 0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0);
      tr += int'(temp_req); zr += int'(zq_req);
      step(0, 0, 0);
      tr += int'(temp_req); zr += int'(zq_req);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tr, zr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 0, "R1 reset cfg", cfg_rdata, 0);
    chk(!temp_req && !zq_req, "R1 reset reqs", {temp_req, zq_req}, 0);

    // R2
    wr(32'h0002_0000, 0);
    chk(cfg_rdata == 32'h0002_0000, "R2 write", cfg_rdata, 32'h0002_0000);
    // R3
    wr(32'hFFFF_FFFF, 1);
    chk(cfg_rdata == 32'h0002_0000, "R3 protected write", cfg_rdata, 32'h0002_0000);

    // R4
    auto_ack = 1; rate_adj_en = 1;
    step(0, 0, 0);
    ticks(30, tr, zr);
    chk(tr == 10, "R4 temp period", tr, 10);

    // R5
    rate_adj_en = 0;
    ticks(12, tr, zr);
    chk(tr == 0, "R5 disabled", tr, 0);
    rate_adj_en = 1; step(0, 0, 0);
    ticks(2, tr, zr);
    chk(tr == 0, "R5 early", tr, 0);
    ticks(1, tr, zr);
    chk(tr == 1, "R5 first after enable", tr, 1);

    // R6
    rate_adj_en = 0;
    wr(32'h0002_0004, 0);
    ticks(20, tr, zr);
    chk(zr == 5, "R6 zq period", zr, 5);

    // R7
    wr(32'h0002_0000, 0);
    ticks(10, tr, zr);
    chk(zr == 0, "R7 zero count", zr, 0);

    // R8
    auto_ack = 0;
    wr(32'h0000_0002, 0);
    ticks(6, tr, zr);
    chk(zq_req == 1, "R8 held", zq_req, 1);
    step(0, 0, 1);
    chk(zq_req == 0, "R8 cleared after ack", zq_req, 0);

    // R9
    auto_ack = 1;
    wr(32'h0000_0004, 0);
    ticks(3, tr, zr);
    wr(32'h0000_0005, 0);
    ticks(4, tr, zr);
    chk(zr == 0, "R9 restart on change", zr, 0);
    ticks(1, tr, zr);
    chk(zr == 1, "R9 expiry after restart", zr, 1);
    ticks(2, tr, zr);
    wr(32'h0000_0005, 0);
    ticks(3, tr, zr);
    chk(zr == 1, "R9 same value keeps count", zr, 1);

    // R10
    auto_ack = 0; rate_adj_en = 1;
    wr(32'h0000_0001, 0);
    step(1, 0, 0);
    chk(zq_req == 1 && temp_req == 0, "R10 zq first", {zq_req, temp_req}, 2'b10);
    step(0, 0, 1);
    chk(zq_req == 0 && temp_req == 1, "R10 temp after zq ack", {zq_req, temp_req}, 2'b01);
    step(0, 1, 0);
    chk(!zq_req && !temp_req, "R10 both cleared", {zq_req, temp_req}, 0);

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        cfg_we = 1;
        cfg_wdata = {16'($urandom_range(0, 4)), 16'($urandom_range(0, 5))};
        wp_en = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 99) == 0) rate_adj_en = ~rate_adj_en;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      cfg_we = 0; wp_en = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule